// File: doc/BRIEF.md
# Serial Status-Memory Write Sequencer

This block is the device-side sequencer for the command that programs the one-time-programmable status bytes of a single-wire serial memory. It sits above the bit-slot layer. Whole bytes arrive on a receive strobe. Whole bytes leave in answer to a read request. The block also reacts to a bus-reset indication and to a programming-pulse indication. Slot timing, the presence pulse, device selection and the programming voltage are handled elsewhere. The sequencer assumes the device has already been selected.

A command starts with the code 0x55. It is followed by the low address byte, the high address byte and one data byte. The block then returns a 16-bit check value. After a programming pulse it returns the stored byte so that the host can verify it. The address then advances and the block waits for the next data byte. On each later byte, the check register is preset to the low byte of the new address instead of carrying over the history of the command. Only a bus reset ends the command.

Top module: `statusProgSeq`

## Requirements
- R1: After power-on reset, `txValid` is low and all status bytes hold 0xFF.
- R2: In the idle state, a received byte other than 0x55 is ignored, and later bytes and read requests produce no response until a 0x55 arrives.
- R3: The first check value is a CRC-16 with polynomial x^16+x^15+x^2+1. It starts from zero and is processed LSB first over the command byte, the address low byte, the address high byte and the data byte, in that order. The block returns its bitwise inverse as two bytes, low byte first. Each byte appears on `txByte` with `txValid` high in the cycle after the `txReq` strobe.
- R4: A programming pulse sets each stored bit of the selected byte to the AND of the stored bit and the host data bit.
- R5: After the pulse, the next `txReq` returns the byte now stored at the selected address, one cycle later.
- R6: Once that verify byte has been returned, the address always increments by one. The next data byte's check value starts from {0x00, low byte of the new address}, and only the data byte is then shifted in, LSB first.
- R7: A programming pulse counts only in the state that follows the second check-value byte. In any other state it leaves the status bytes unchanged.
- R8: An address of 8 or more, including any non-zero high byte, leaves the status bytes unchanged, and its verify read returns 0xFF. Addresses 0 to 7 select the byte with that index.
- R9: `busReset` returns the sequencer to idle in any state. It wins over a programming pulse in the same cycle, and the status bytes keep their values across it.
- R10: `txValid` rises only in the cycle after a `txReq` that fell in a check-value or verify state. A request in any other state gets no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset; also restores the status bytes |
| busReset | input | 1 | One-cycle bus-reset indication from the slot layer |
| rxValid | input | 1 | Strobe: a host byte is on `rxByte` |
| rxByte | input | 8 | Received byte; bit 0 was first on the wire |
| txReq | input | 1 | Strobe: the host has started eight read slots |
| txValid | output | 1 | Response byte valid on `txByte` |
| txByte | output | 8 | Response byte; bit 0 goes first on the wire |
| progPulse | input | 1 | One-cycle indication that a programming pulse occurred |

## Verification
Two functions can fall in the same cycle: a programming pulse and a bus reset. The bench raises both in the cycle where the pulse would otherwise be accepted. It then confirms two things: no read request is answered afterwards, and a later verify read of that address still returns its earlier value. A stray pulse is also sent while a stale data byte is still latched, and the next verify of that address must show no change. The sweeps walk several starting addresses past the end of the array. At every step they compare both check-value bytes and the verify byte with values computed arithmetically in the bench.

// File: rtl/statusProgPkg.sv
package statusProgPkg;

  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR_LO,
    ST_ADDR_HI,
    ST_DATA,
    ST_CRC_LO,
    ST_CRC_HI,
    ST_WAIT_PROG,
    ST_VERIFY
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic crcClear;     // restart check register from zero before the shift
    logic crcShift;     // shift rxByte into the check register
    logic crcLoadAddr;  // preset check register with low byte of next address
    logic latchAddrLo;
    logic latchAddrHi;
    logic latchData;
    logic doProgram;
    logic advance;
    logic sendCrcLo;
    logic sendCrcHi;
    logic sendVerify;
  } seqStrobe_t;

  // reflected CRC step over one byte, LSB first
  function automatic logic [15:0] crcByteStep(input logic [15:0] crcIn,
                                              input logic [7:0]  din,
                                              input logic [15:0] polyRefl);
    logic [15:0] c;
    logic        fb;
    c = crcIn;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ din[i];
      c  = c >> 1;
      if (fb) c = c ^ polyRefl;
    end
    return c;
  endfunction

endpackage

// File: rtl/statusProgCtrl.sv
module statusProgCtrl
  import statusProgPkg::*;
#(
  parameter logic [7:0] CMD_CODE = 8'h55
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReq,
  input  logic       progPulse,
  output seqState_t  state,
  output seqStrobe_t strb
);

  seqState_t nextState;

  always_comb begin
    nextState = state;
    strb      = '0;
    if (busReset) begin
      nextState = ST_IDLE;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (rxValid && rxByte == CMD_CODE) begin
            strb.crcClear = 1'b1;
            strb.crcShift = 1'b1;
            nextState     = ST_ADDR_LO;
          end
        end
        ST_ADDR_LO: begin
          if (rxValid) begin
            strb.latchAddrLo = 1'b1;
            strb.crcShift    = 1'b1;
            nextState        = ST_ADDR_HI;
          end
        end
        ST_ADDR_HI: begin
          if (rxValid) begin
            strb.latchAddrHi = 1'b1;
            strb.crcShift    = 1'b1;
            nextState        = ST_DATA;
          end
        end
        ST_DATA: begin
          if (rxValid) begin
            strb.latchData = 1'b1;
            strb.crcShift  = 1'b1;
            nextState      = ST_CRC_LO;
          end
        end
        ST_CRC_LO: begin
          if (txReq) begin
            strb.sendCrcLo = 1'b1;
            nextState      = ST_CRC_HI;
          end
        end
        ST_CRC_HI: begin
          if (txReq) begin
            strb.sendCrcHi = 1'b1;
            nextState      = ST_WAIT_PROG;
          end
        end
        ST_WAIT_PROG: begin
          if (progPulse) begin
            strb.doProgram = 1'b1;
            nextState      = ST_VERIFY;
          end
        end
        ST_VERIFY: begin
          if (txReq) begin
            strb.sendVerify  = 1'b1;
            strb.advance     = 1'b1;
            strb.crcLoadAddr = 1'b1;
            nextState        = ST_DATA;
          end
        end
        default: nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

endmodule

// File: rtl/statusProgDp.sv
module statusProgDp
  import statusProgPkg::*;
#(
  parameter int          STATUS_BYTES = 8,
  parameter logic [15:0] CRC_POLY     = 16'hA001
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  seqStrobe_t                strb,
  input  logic [7:0]                rxByte,
  output logic                      txValid,
  output logic [7:0]                txByte,
  output logic [ADDR_W-1:0]         curAddr,
  output logic [STATUS_BYTES*8-1:0] memFlat
);

  localparam int IDX_W = (STATUS_BYTES > 1) ? $clog2(STATUS_BYTES) : 1;
  localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(STATUS_BYTES);

  logic [ADDR_W-1:0] addrReg;
  logic [15:0]       crcReg;
  logic [7:0]        dataReg;
  logic [7:0]        mem [STATUS_BYTES];

  logic              inRange;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] addrNext;
  logic [15:0]       crcBase;

  assign inRange  = addrReg < LIMIT;
  assign idx      = addrReg[IDX_W-1:0];
  assign addrNext = addrReg + 1'b1;
  assign crcBase  = strb.crcClear ? 16'h0000 : crcReg;
  assign curAddr  = addrReg;

  // address, data and check register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrReg <= '0;
      dataReg <= '0;
      crcReg  <= '0;
    end else begin
      if (strb.latchAddrLo) addrReg[7:0]        <= rxByte;
      if (strb.latchAddrHi) addrReg[ADDR_W-1:8] <= rxByte;
      if (strb.advance)     addrReg             <= addrNext;
      if (strb.latchData)   dataReg             <= rxByte;
      if (strb.crcLoadAddr) crcReg <= {8'h00, addrNext[7:0]};
      else if (strb.crcShift) crcReg <= crcByteStep(crcBase, rxByte, CRC_POLY);
    end
  end

  // status array: restored only by power-on reset
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STATUS_BYTES; i++) mem[i] <= 8'hFF;
    end else if (strb.doProgram && inRange) begin
      mem[idx] <= mem[idx] & dataReg;
    end
  end

  // response byte
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txValid <= 1'b0;
      txByte  <= '0;
    end else begin
      txValid <= strb.sendCrcLo | strb.sendCrcHi | strb.sendVerify;
      if (strb.sendCrcLo)       txByte <= ~crcReg[7:0];
      else if (strb.sendCrcHi)  txByte <= ~crcReg[15:8];
      else if (strb.sendVerify) txByte <= inRange ? mem[idx] : 8'hFF;
    end
  end

  for (genvar g = 0; g < STATUS_BYTES; g++) begin : gFlat
    assign memFlat[g*8 +: 8] = mem[g];
  end

endmodule

// File: rtl/statusProgSeq.sv
module statusProgSeq
  import statusProgPkg::*;
#(
  parameter int          STATUS_BYTES = 8,
  parameter logic [7:0]  CMD_CODE     = 8'h55,
  parameter logic [15:0] CRC_POLY     = 16'hA001
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReset,
  input  logic       rxValid,
  input  logic [7:0] rxByte,
  input  logic       txReq,
  output logic       txValid,
  output logic [7:0] txByte,
  input  logic       progPulse
);

  seqState_t                 seqState;
  seqStrobe_t                seqStrb;
  logic [ADDR_W-1:0]         curAddr;
  logic [STATUS_BYTES*8-1:0] memFlat;

  statusProgCtrl #(.CMD_CODE(CMD_CODE)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReset (busReset),
    .rxValid  (rxValid),
    .rxByte   (rxByte),
    .txReq    (txReq),
    .progPulse(progPulse),
    .state    (seqState),
    .strb     (seqStrb)
  );

  statusProgDp #(.STATUS_BYTES(STATUS_BYTES), .CRC_POLY(CRC_POLY)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (seqStrb),
    .rxByte  (rxByte),
    .txValid (txValid),
    .txByte  (txByte),
    .curAddr (curAddr),
    .memFlat (memFlat)
  );

endmodule

// File: rtl/statusProgChk.sv
module statusProgChk
  import statusProgPkg::*;
#(
  parameter int         STATUS_BYTES = 8,
  parameter logic [7:0] CMD_CODE     = 8'h55
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      busReset,
  input logic                      rxValid,
  input logic [7:0]                rxByte,
  input logic                      txReq,
  input logic                      txValid,
  input logic                      progPulse,
  input seqState_t                 state,
  input logic [ADDR_W-1:0]         curAddr,
  input logic [STATUS_BYTES*8-1:0] memFlat
);

  // R2: a wrong command byte keeps the sequencer idle
  a_r2_bad_cmd_stays_idle: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && rxValid && rxByte != CMD_CODE && !busReset) |=> state == ST_IDLE);

  // R4: programming can only clear bits
  a_r4_bits_only_clear: assert property (@(posedge clk) disable iff (!rstN)
    (memFlat & ~$past(memFlat)) == '0);

  // R6: the verify read always advances the address
  a_r6_addr_advances: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_VERIFY && txReq && !busReset) |=> curAddr == ADDR_W'($past(curAddr) + 1'b1));

  // R7: the array changes only after an accepted pulse
  a_r7_prog_only_when_armed: assert property (@(posedge clk) disable iff (!rstN)
    (memFlat != $past(memFlat)) |-> $past(progPulse && state == ST_WAIT_PROG && !busReset));

  // R9: bus reset always lands in idle
  a_r9_bus_reset_idle: assert property (@(posedge clk) disable iff (!rstN)
    busReset |=> state == ST_IDLE);

  // R10: a response only follows a request
  a_r10_resp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> $past(txReq && !busReset));

endmodule

bind statusProgSeq statusProgChk #(.STATUS_BYTES(STATUS_BYTES), .CMD_CODE(CMD_CODE)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busReset (busReset),
  .rxValid  (rxValid),
  .rxByte   (rxByte),
  .txReq    (txReq),
  .txValid  (txValid),
  .progPulse(progPulse),
  .state    (seqState),
  .curAddr  (curAddr),
  .memFlat  (memFlat)
);

// File: tb/sim_statusProgSeq.sv
`timescale 1ns/1ps
module sim_statusProgSeq;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busReset = 1'b0;
  logic       rxValid = 1'b0;
  logic [7:0] rxByte = 8'h00;
  logic       txReq = 1'b0;
  logic       txValid;
  logic [7:0] txByte;
  logic       progPulse = 1'b0;

  int nChecks = 0;
  int nFail   = 0;
  bit doneFlag = 1'b0;

  logic [7:0]  mdl [8];
  logic [15:0] bAddr;
  logic [15:0] bCrc;

  always #2.5 clk = ~clk;

  statusProgSeq u0 (
    .clk(clk), .rstN(rstN), .busReset(busReset), .rxValid(rxValid),
    .rxByte(rxByte), .txReq(txReq), .txValid(txValid), .txByte(txByte),
    .progPulse(progPulse)
  );

  function automatic logic [15:0] refCrc(input logic [15:0] c0, input logic [7:0] d);
    logic [15:0] c;
    c = c0;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ d[i]) c = (c >> 1) ^ 16'hA001;
      else             c = c >> 1;
    end
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] b);
    @(negedge clk); rxValid = 1'b1; rxByte = b;
    @(negedge clk); rxValid = 1'b0;
  endtask

  task automatic readByte(output logic v, output logic [7:0] b);
    @(negedge clk); txReq = 1'b1;
    @(negedge clk); txReq = 1'b0; v = txValid; b = txByte;
  endtask

  task automatic pulse();
    @(negedge clk); progPulse = 1'b1;
    @(negedge clk); progPulse = 1'b0;
  endtask

  task automatic startCmd(input logic [15:0] a);
    sendByte(8'h55); sendByte(a[7:0]); sendByte(a[15:8]);
    bAddr = a;
    bCrc  = refCrc(refCrc(refCrc(16'h0000, 8'h55), a[7:0]), a[15:8]);
  endtask

  // one data byte: crc readback, pulse, verify, address advance
  task automatic writeStep(input logic [7:0] d, input bit first);
    logic v; logic [7:0] b; logic [15:0] exp16; logic [7:0] expV;
    if (!first) bCrc = {8'h00, bAddr[7:0]};
    bCrc = refCrc(bCrc, d);
    exp16 = ~bCrc;
    sendByte(d);
    readByte(v, b);
    chk(v && b == exp16[7:0], first ? "R3 crc lo" : "R6 crc lo", {7'd0, v, b}, {8'h01, exp16[7:0]});
    readByte(v, b);
    chk(v && b == exp16[15:8], first ? "R3 crc hi" : "R6 crc hi", {7'd0, v, b}, {8'h01, exp16[15:8]});
    pulse();
    if (bAddr < 16'd8) begin
      mdl[bAddr[2:0]] = mdl[bAddr[2:0]] & d;
      expV = mdl[bAddr[2:0]];
    end else begin
      expV = 8'hFF;
    end
    readByte(v, b);
    chk(v && b == expV, (bAddr < 16'd8) ? "R4/R5 verify" : "R8 out of range verify",
        {7'd0, v, b}, {8'h01, expV});
    bAddr = bAddr + 16'd1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!doneFlag) begin
      nFail++;
      $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic v; logic [7:0] b;
    for (int i = 0; i < 8; i++) mdl[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(txValid == 1'b0, "R1 txValid after reset", {15'd0, txValid}, 16'd0);

    // R10: read request while idle
    readByte(v, b);
    chk(v == 1'b0, "R10 no response in idle", {15'd0, v}, 16'd0);

    // R2: wrong command, then bytes that look like a command body
    sendByte(8'hAA); sendByte(8'h00); sendByte(8'h00); sendByte(8'h00);
    readByte(v, b);
    chk(v == 1'b0, "R2 wrong command ignored", {15'd0, v}, 16'd0);
    pulse();
    readByte(v, b);
    chk(v == 1'b0, "R2 still idle", {15'd0, v}, 16'd0);

    // R1: untouched bytes read 0xFF (data 0xFF changes nothing)
    startCmd(16'h0000);
    for (int k = 0; k < 8; k++) writeStep(8'hFF, k == 0);
    busReset_task();

    // sweeps over start address and pattern, running past the array
    for (int r = 0; r < 4; r++) begin
      startCmd(16'(r * 2));
      for (int k = 0; bAddr < 16'd10; k++) begin
        logic [7:0] d;
        if (r < 2) d = ~(8'h01 << ((bAddr[2:0] + 3'(r)) & 3'h7));
        else       d = 8'hFF ^ 8'(bAddr * 16'(r) * 16'd13 + 16'd5);
        writeStep(d, k == 0);
      end
      busReset_task();
    end

    // R8: non-zero high byte addresses nothing
    startCmd(16'h0103);
    writeStep(8'h00, 1'b1);
    busReset_task();

    // R7: stray pulse while a stale all-zero byte is latched
    startCmd(16'h0005);
    sendByte(8'h00);
    busReset_task();
    startCmd(16'h0005);
    pulse();
    writeStep(8'hFF, 1'b1);
    busReset_task();

    // R9: bus reset together with pulse in the armed state
    startCmd(16'h0003);
    sendByte(8'h00);
    readByte(v, b);
    readByte(v, b);
    @(negedge clk); busReset = 1'b1; progPulse = 1'b1;
    @(negedge clk); busReset = 1'b0; progPulse = 1'b0;
    readByte(v, b);
    chk(v == 1'b0, "R9 no verify after bus reset", {15'd0, v}, 16'd0);

    // final readback of whole array (R7, R8, R9 retention)
    startCmd(16'h0000);
    for (int k = 0; k < 8; k++) writeStep(8'hFF, k == 0);
    busReset_task();

    doneFlag = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  task automatic busReset_task();
    @(negedge clk); busReset = 1'b1;
    @(negedge clk); busReset = 1'b0;
  endtask

endmodule